// File: doc/BRIEF.md
# Virtualized CSR Access Fault Classifier

This block sits beside the CSR instruction decoder of a hart that implements the hypervisor extension and the advanced interrupt architecture. For each CSR access attempt it returns one of three verdicts: allow, illegal-instruction exception, or virtual-instruction exception. The inputs are the current privilege, the 12-bit CSR address and the read/write intent. The verdict also depends on the trap-virtual-memory control, the machine state-enable word, the two interrupt select registers, and two configuration flags. One flag says the interrupt architecture is supported; the other says an interrupt file (IMSIC) is present.

For virtualized modes the rule is a replay. The same access is evaluated as if it came from HS-mode with trap-virtual-memory forced to zero. A virtual-instruction exception is raised only when that replay would succeed, so an access that HS-mode itself could not make stays an illegal-instruction exception. High-half CSRs never take the virtual path. For the supervisor top-of-interrupt register, support for the interrupt architecture matters more than whether an interrupt file exists: a VS-mode access with no interrupt file present is handed to the hypervisor for emulation.

The verdict is registered. It appears on the cycle after the request strobe and holds until the next request. CSR storage, data movement, trap entry and the interrupt file itself live elsewhere.

Top module: `csr_fault_classifier`

## Requirements
- R1: The outputs are cleared by reset. `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. The verdict fields change only on such cycles and otherwise hold their last value.
- R2: Exactly one of `out_allow` and `out_exc` is high with each verdict. `out_cause` is 0 when the access is allowed, 2 for an illegal-instruction exception and 22 for a virtual-instruction exception.
- R3: The privilege is encoded on `req_priv` as 000 U, 001 HS, 011 M, 100 VU, 101 VS. Any other code, or an unimplemented CSR address, gives cause 2. The implemented set is:
  - 0x100, 0x180, 0x200, 0x600, 0x605, 0x680, 0x300 and 0xC00 always.
  - 0x150, 0x151, 0x15C, 0x250, 0x251 and 0x25C when the interrupt architecture is supported.
  - 0x35C when it is supported and an interrupt file is present.
  - High halves 0x615 and 0xC80 when XLEN is 32.
- R4: From M-mode every implemented CSR is allowed, except a write to a read-only CSR (address bits [11:10] = 11), which gives cause 2. M-mode never sees cause 22.
- R5: CSR address bits [9:8] give the level a CSR needs (00 user, 01 supervisor, 10 hypervisor/VS, 11 machine). From U, VS or VU, a user-level CSR is allowed unless the access is a write to a read-only CSR. A machine-level CSR gives cause 2 from any mode below M, and U-mode gets cause 2 for every CSR that is not user-level.
- R6: From HS-mode, supervisor- and hypervisor-level CSRs are allowed unless one of the following applies, in which case the result is cause 2:
  - the access is a write to a read-only CSR;
  - the trap-virtual-memory input is 1 and the address is 0x180 or 0x680;
  - a gating or select rule fails.
- R7: Below M-mode, the select registers 0x150 and 0x250 and the indirect aliases 0x151 and 0x251 need state-enable bit 60 set. Without it, HS-mode and VS-mode's own view get cause 2.
- R8: An indirect alias access is not legal while the select register it reads is 0. 0x251 always reads the VS select value. 0x151 reads the supervisor select value from HS-mode and from the VU replay, and the VS select value from VS-mode.
- R9: From VS-mode, a hypervisor-level CSR that is not high-half gives cause 22 when the HS replay (trap-virtual-memory taken as 0) succeeds, and cause 2 otherwise.
- R10: From VU-mode, a supervisor- or hypervisor-level CSR that is not high-half gives cause 22 when the HS replay succeeds, and cause 2 otherwise.
- R11: A high-half CSR at supervisor or hypervisor level accessed from VS or VU always gives cause 2.
- R12: With the interrupt architecture supported and no interrupt file, a VS-mode access to 0x15C gives cause 22, whatever state-enable bit 58 holds.
- R13: From HS-mode and in the replay, 0x15C and 0x25C are legal only with an interrupt file present and state-enable bit 58 set.
- R14: From VS-mode, a supervisor-level CSR is judged by VS-mode's own view: the R7, R8 and R13 rules apply, with trap-virtual-memory ignored. The result is allow, or cause 2 when a rule fails (R12 excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_priv | input | 3 | Current privilege code |
| req_addr | input | 12 | CSR address |
| req_write | input | 1 | 1 for an access that writes |
| tvm | input | 1 | Trap-virtual-memory control |
| stateen0 | input | STATEEN_W (64) | Machine state-enable word 0 |
| sisel_val | input | SEL_W (12) | Supervisor interrupt select value |
| vssel_val | input | SEL_W (12) | VS interrupt select value |
| cfg_aia | input | 1 | Interrupt architecture supported |
| cfg_imsic | input | 1 | Interrupt file present |
| out_valid | output | 1 | Verdict valid this cycle |
| out_allow | output | 1 | Access allowed |
| out_exc | output | 1 | Access raises an exception |
| out_cause | output | CAUSE_W (5) | Exception cause code |

## Verification
The bench sweeps every privilege code, including the reserved ones, against a list of CSR addresses. The list includes an unimplemented address. Each combination is tried with both trap-virtual-memory values and both directions. The sweep covers every combination of the two configuration flags, the four settings of state-enable bits 58 and 60, and three pairs of select values.

Each setting separates one rule from a neighbour:
- The trap-virtual-memory flip separates the live HS check from the replay on 0x180 and 0x680.
- The select pairs with only one side zero show which select register each indirect alias reads.
- Dropping the interrupt file while keeping support for the interrupt architecture separates the VS top-of-interrupt emulation case from the HS-qualification rule.

Idle cycles are placed between requests to check that the verdict lasts exactly one cycle and holds afterwards.

// File: rtl/csr_fault_pkg.sv
package csr_fault_pkg;

   // privilege codes: bit 2 marks a virtualized mode
   localparam logic [2:0] PRV_U  = 3'b000;
   localparam logic [2:0] PRV_HS = 3'b001;
   localparam logic [2:0] PRV_M  = 3'b011;
   localparam logic [2:0] PRV_VU = 3'b100;
   localparam logic [2:0] PRV_VS = 3'b101;

   // required-level field values (address bits [9:8])
   localparam logic [1:0] LVL_USER = 2'b00;
   localparam logic [1:0] LVL_SUP  = 2'b01;
   localparam logic [1:0] LVL_HYP  = 2'b10;
   localparam logic [1:0] LVL_MACH = 2'b11;

   localparam logic [11:0] A_SSTATUS    = 12'h100;
   localparam logic [11:0] A_SATP       = 12'h180;
   localparam logic [11:0] A_SISEL      = 12'h150;
   localparam logic [11:0] A_SIREG      = 12'h151;
   localparam logic [11:0] A_STOPEI     = 12'h15C;
   localparam logic [11:0] A_VSSTATUS   = 12'h200;
   localparam logic [11:0] A_VSISEL     = 12'h250;
   localparam logic [11:0] A_VSIREG     = 12'h251;
   localparam logic [11:0] A_VSTOPEI    = 12'h25C;
   localparam logic [11:0] A_HSTATUS    = 12'h600;
   localparam logic [11:0] A_HTDELTA    = 12'h605;
   localparam logic [11:0] A_HTDELTA_HI = 12'h615;
   localparam logic [11:0] A_HGATP      = 12'h680;
   localparam logic [11:0] A_MSTATUS    = 12'h300;
   localparam logic [11:0] A_MTOPEI     = 12'h35C;
   localparam logic [11:0] A_CYCLE      = 12'hC00;
   localparam logic [11:0] A_CYCLE_HI   = 12'hC80;

   localparam int unsigned CODE_ILLEGAL = 2;
   localparam int unsigned CODE_VIRTUAL = 22;

   typedef struct packed {
      logic       impl;      // exists in this configuration
      logic [1:0] lvl;       // required level
      logic       ro;        // read-only
      logic       hh;        // high-half register
      logic       tvm_trap;  // trapped by trap-virtual-memory in HS
      logic       gate_top;  // top-of-interrupt gating
      logic       gate_ind;  // select / indirect gating
      logic       is_sireg;
      logic       is_vsireg;
      logic       is_stopei;
   } csr_attr_t;

   typedef enum logic [1:0] {
      VRD_ALLOW   = 2'd0,
      VRD_ILLEGAL = 2'd1,
      VRD_VIRTUAL = 2'd2
   } verdict_e;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
   import csr_fault_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [11:0] addr,
   input  logic        cfg_aia,
   input  logic        cfg_imsic,
   output csr_attr_t   attr
);

   logic high_present;

   generate
      if (XLEN == 32) begin : g_rv32
         assign high_present = 1'b1;
      end else begin : g_rv64
         assign high_present = 1'b0;
      end
   endgenerate

   logic known;
   logic need_aia;
   logic need_imsic;
   logic high;
   logic tvm_trap;
   logic gate_top;
   logic gate_ind;
   logic is_sireg;
   logic is_vsireg;
   logic is_stopei;

   always_comb begin
      known      = 1'b1;
      need_aia   = 1'b0;
      need_imsic = 1'b0;
      high       = 1'b0;
      tvm_trap   = 1'b0;
      gate_top   = 1'b0;
      gate_ind   = 1'b0;
      is_sireg   = 1'b0;
      is_vsireg  = 1'b0;
      is_stopei  = 1'b0;
      case (addr)
         A_SSTATUS, A_VSSTATUS, A_HSTATUS,
         A_HTDELTA, A_MSTATUS, A_CYCLE: ;
         A_SATP, A_HGATP:        tvm_trap = 1'b1;
         A_SISEL, A_VSISEL: begin
            need_aia = 1'b1;
            gate_ind = 1'b1;
         end
         A_SIREG: begin
            need_aia = 1'b1;
            gate_ind = 1'b1;
            is_sireg = 1'b1;
         end
         A_VSIREG: begin
            need_aia  = 1'b1;
            gate_ind  = 1'b1;
            is_vsireg = 1'b1;
         end
         A_STOPEI: begin
            need_aia  = 1'b1;
            gate_top  = 1'b1;
            is_stopei = 1'b1;
         end
         A_VSTOPEI: begin
            need_aia = 1'b1;
            gate_top = 1'b1;
         end
         A_MTOPEI: begin
            need_aia   = 1'b1;
            need_imsic = 1'b1;
         end
         A_HTDELTA_HI, A_CYCLE_HI: high = 1'b1;
         default:                  known = 1'b0;
      endcase
   end

   always_comb begin
      attr           = '0;
      attr.impl      = known && (!need_aia || cfg_aia) && (!need_imsic || cfg_imsic)
                       && (!high || high_present);
      attr.lvl       = addr[9:8];
      attr.ro        = &addr[11:10];
      attr.hh        = high;
      attr.tvm_trap  = tvm_trap;
      attr.gate_top  = gate_top;
      attr.gate_ind  = gate_ind;
      attr.is_sireg  = is_sireg;
      attr.is_vsireg = is_vsireg;
      attr.is_stopei = is_stopei;
   end

endmodule

// File: rtl/csr_hs_replay.sv
module csr_hs_replay
   import csr_fault_pkg::*;
#(
   parameter int SEL_W = 12
) (
   input  csr_attr_t          attr,
   input  logic               write,
   input  logic               tvm_eff,
   input  logic               imsic,
   input  logic               top_en,
   input  logic               ind_en,
   input  logic               vs_view,
   input  logic [SEL_W-1:0]   sisel,
   input  logic [SEL_W-1:0]   vssel,
   output logic               ok
);

   logic [SEL_W-1:0] sel_pick;
   logic             sel_bad;
   logic             level_ok;
   logic             write_ok;
   logic             tvm_ok;
   logic             top_ok;
   logic             ind_ok;

   always_comb begin
      sel_pick = (attr.is_vsireg || (attr.is_sireg && vs_view)) ? vssel : sisel;
      sel_bad  = (attr.is_sireg || attr.is_vsireg) && (sel_pick == '0);
      level_ok = (attr.lvl != LVL_MACH);
      write_ok = !(write && attr.ro);
      tvm_ok   = !(tvm_eff && attr.tvm_trap);
      top_ok   = !attr.gate_top || (top_en && imsic);
      ind_ok   = !attr.gate_ind || ind_en;
      ok       = attr.impl && level_ok && write_ok && tvm_ok && top_ok && ind_ok && !sel_bad;
   end

endmodule

// File: rtl/csr_verdict_sel.sv
module csr_verdict_sel
   import csr_fault_pkg::*;
(
   input  logic [2:0] priv,
   input  logic       write,
   input  csr_attr_t  attr,
   input  logic       ok_live,
   input  logic       ok_replay,
   input  logic       ok_vsnat,
   input  logic       cfg_imsic,
   output verdict_e   verdict
);

   logic ro_write;
   logic virt_or_illegal;

   always_comb begin
      ro_write        = write && attr.ro;
      virt_or_illegal = !attr.hh && ok_replay;
      verdict         = VRD_ILLEGAL;
      if (attr.impl) begin
         case (priv)
            PRV_M:  verdict = ro_write ? VRD_ILLEGAL : VRD_ALLOW;
            PRV_U:  verdict = (attr.lvl == LVL_USER && !ro_write) ? VRD_ALLOW : VRD_ILLEGAL;
            PRV_HS: verdict = ok_live ? VRD_ALLOW : VRD_ILLEGAL;
            PRV_VS: begin
               case (attr.lvl)
                  LVL_USER: verdict = ro_write ? VRD_ILLEGAL : VRD_ALLOW;
                  LVL_SUP: begin
                     if (attr.is_stopei && !cfg_imsic) verdict = VRD_VIRTUAL;
                     else                              verdict = ok_vsnat ? VRD_ALLOW : VRD_ILLEGAL;
                  end
                  LVL_HYP:  verdict = virt_or_illegal ? VRD_VIRTUAL : VRD_ILLEGAL;
                  default:  verdict = VRD_ILLEGAL;
               endcase
            end
            PRV_VU: begin
               case (attr.lvl)
                  LVL_USER:         verdict = ro_write ? VRD_ILLEGAL : VRD_ALLOW;
                  LVL_SUP, LVL_HYP: verdict = virt_or_illegal ? VRD_VIRTUAL : VRD_ILLEGAL;
                  default:          verdict = VRD_ILLEGAL;
               endcase
            end
            default: verdict = VRD_ILLEGAL;
         endcase
      end
   end

endmodule

// File: rtl/csr_fault_classifier.sv
module csr_fault_classifier
   import csr_fault_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int STATEEN_W = 64,
   parameter int TOP_BIT   = 58,
   parameter int IND_BIT   = 60,
   parameter int SEL_W     = 12,
   parameter int CAUSE_W   = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [2:0]           req_priv,
   input  logic [11:0]          req_addr,
   input  logic                 req_write,
   input  logic                 tvm,
   input  logic [STATEEN_W-1:0] stateen0,
   input  logic [SEL_W-1:0]     sisel_val,
   input  logic [SEL_W-1:0]     vssel_val,
   input  logic                 cfg_aia,
   input  logic                 cfg_imsic,
   output logic                 out_valid,
   output logic                 out_allow,
   output logic                 out_exc,
   output logic [CAUSE_W-1:0]   out_cause
);

   localparam int N_VIEW   = 3;   // 0: VS own view, 1: HS replay, 2: live HS
   localparam int V_VSNAT  = 0;
   localparam int V_REPLAY = 1;
   localparam int V_LIVE   = 2;
   localparam logic [CAUSE_W-1:0] C_ILL  = CAUSE_W'(CODE_ILLEGAL);
   localparam logic [CAUSE_W-1:0] C_VIRT = CAUSE_W'(CODE_VIRTUAL);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("XLEN must be 32 or 64");
      end
      if (TOP_BIT >= STATEEN_W || IND_BIT >= STATEEN_W) begin : g_bad_bits
         $error("state-enable bit positions exceed the word width");
      end
      if (SEL_W < 1 || SEL_W > XLEN) begin : g_bad_sel
         $error("SEL_W out of range");
      end
      if ((1 << CAUSE_W) <= CODE_VIRTUAL) begin : g_bad_cause
         $error("CAUSE_W too narrow for the cause codes");
      end
   endgenerate

   csr_attr_t   attr;
   logic [N_VIEW-1:0] view_ok;
   verdict_e    verdict;

   csr_addr_decode #(.XLEN(XLEN)) u_decode (
      .addr      (req_addr),
      .cfg_aia   (cfg_aia),
      .cfg_imsic (cfg_imsic),
      .attr      (attr)
   );

   genvar gv;
   generate
      for (gv = 0; gv < N_VIEW; gv++) begin : g_view
         csr_hs_replay #(.SEL_W(SEL_W)) u_view (
            .attr    (attr),
            .write   (req_write),
            .tvm_eff ((gv == V_LIVE) ? tvm : 1'b0),
            .imsic   (cfg_imsic),
            .top_en  (stateen0[TOP_BIT]),
            .ind_en  (stateen0[IND_BIT]),
            .vs_view ((gv == V_VSNAT) ? 1'b1 : 1'b0),
            .sisel   (sisel_val),
            .vssel   (vssel_val),
            .ok      (view_ok[gv])
         );
      end
   endgenerate

   csr_verdict_sel u_sel (
      .priv      (req_priv),
      .write     (req_write),
      .attr      (attr),
      .ok_live   (view_ok[V_LIVE]),
      .ok_replay (view_ok[V_REPLAY]),
      .ok_vsnat  (view_ok[V_VSNAT]),
      .cfg_imsic (cfg_imsic),
      .verdict   (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_allow <= 1'b0;
         out_exc   <= 1'b0;
         out_cause <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            out_allow <= (verdict == VRD_ALLOW);
            out_exc   <= (verdict != VRD_ALLOW);
            case (verdict)
               VRD_ALLOW:   out_cause <= '0;
               VRD_VIRTUAL: out_cause <= C_VIRT;
               default:     out_cause <= C_ILL;
            endcase
         end
      end
   end

   // R1: verdict strobe trails the request by one cycle
   assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(req_valid)));

   // R2: exactly one of allow / exception
   assert_one_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_allow != out_exc));

   // R2: cause code follows the verdict kind
   assert_cause_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_allow ? (out_cause == '0)
                               : (out_cause == C_ILL || out_cause == C_VIRT)));

   // R3: unimplemented address always illegal
   assert_unimpl_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid && !$past(attr.impl)) |-> (out_exc && out_cause == C_ILL));

   // R4: machine mode never takes the virtual path
   assert_machine_not_virtual_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid && $past(req_priv) == PRV_M) |-> (out_cause != C_VIRT));

   // R9 / R10: only virtualized modes see the virtual cause
   assert_virtual_only_when_virt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid && !$past(req_priv[2])) |-> (out_cause != C_VIRT));

   // R11: high-half registers never become virtual faults
   assert_highhalf_not_virtual_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid && $past(attr.hh)) |-> (out_cause != C_VIRT));

endmodule

// File: tb/csr_fault_classifier_bench.sv
`timescale 1ns/1ps
module csr_fault_classifier_bench;

   localparam int SEL_W = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_priv = '0;
   logic [11:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        tvm = 1'b0;
   logic [63:0] stateen0 = '0;
   logic [SEL_W-1:0] sisel_val = '0;
   logic [SEL_W-1:0] vssel_val = '0;
   logic        cfg_aia = 1'b0;
   logic        cfg_imsic = 1'b0;
   logic        out_valid;
   logic        out_allow;
   logic        out_exc;
   logic [4:0]  out_cause;

   always #2 clk = ~clk;   // 250 MHz

   csr_fault_classifier u_csr_fault_classifier (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
      .req_addr(req_addr), .req_write(req_write), .tvm(tvm), .stateen0(stateen0),
      .sisel_val(sisel_val), .vssel_val(vssel_val), .cfg_aia(cfg_aia),
      .cfg_imsic(cfg_imsic), .out_valid(out_valid), .out_allow(out_allow),
      .out_exc(out_exc), .out_cause(out_cause)
   );

   typedef struct {
      bit    v;
      bit    allow;
      int    cause;
      string tag;
   } expect_t;

   expect_t pending[$];
   int checks = 0;
   int failures = 0;
   bit last_allow = 0;
   int last_cause = 0;

   localparam int ADDRS [18] = '{12'h100, 12'h180, 12'h150, 12'h151, 12'h15C, 12'h200,
                                 12'h250, 12'h251, 12'h25C, 12'h600, 12'h605, 12'h615,
                                 12'h680, 12'h300, 12'h35C, 12'hC00, 12'hC80, 12'h7FF};

   function automatic bit exists(int a, bit aia, bit imsic);
      case (a)
         12'h100, 12'h180, 12'h200, 12'h600, 12'h605, 12'h680, 12'h300, 12'hC00: return 1;
         12'h150, 12'h151, 12'h15C, 12'h250, 12'h251, 12'h25C: return aia;
         12'h35C: return aia && imsic;
         12'h615, 12'hC80: return 1;   // XLEN 32 default
         default: return 0;
      endcase
   endfunction

   function automatic bit hs_can(int a, bit w, bit tv, bit vsview, bit b58, bit b60,
                                 int ssel, int vsel, bit imsic, bit ex);
      if (!ex) return 0;
      if (((a >> 8) & 3) == 3) return 0;
      if (w && ((a >> 10) & 3) == 3) return 0;
      if (tv && (a == 12'h180 || a == 12'h680)) return 0;
      if ((a == 12'h15C || a == 12'h25C) && !(b58 && imsic)) return 0;
      if ((a == 12'h150 || a == 12'h151 || a == 12'h250 || a == 12'h251) && !b60) return 0;
      if (a == 12'h251 && vsel == 0) return 0;
      if (a == 12'h151 && (vsview ? vsel : ssel) == 0) return 0;
      return 1;
   endfunction

   function automatic string hs_tag(int a);
      if (a == 12'h15C || a == 12'h25C || a == 12'h35C) return "R13";
      if (a == 12'h151 || a == 12'h251) return "R8";
      if (a == 12'h150 || a == 12'h250) return "R7";
      return "R6";
   endfunction

   function automatic expect_t reference(int prv, int a, bit w, bit tv, bit b58, bit b60,
                                         int ssel, int vsel, bit aia, bit imsic);
      expect_t e;
      int  lvl = (a >> 8) & 3;
      bit  rw  = w && (((a >> 10) & 3) == 3);
      bit  hh  = (a == 12'h615 || a == 12'hC80);
      bit  ex  = exists(a, aia, imsic);
      e.v = 1; e.allow = 0; e.cause = 2; e.tag = "R3";
      if (!ex || !(prv == 0 || prv == 1 || prv == 3 || prv == 4 || prv == 5)) begin
         if (a == 12'h35C) e.tag = "R13";
         return e;
      end
      case (prv)
         3: begin e.tag = "R4"; e.allow = !rw; end
         0: begin e.tag = "R5"; e.allow = (lvl == 0) && !rw; end
         1: begin e.tag = hs_tag(a); e.allow = hs_can(a, w, tv, 0, b58, b60, ssel, vsel, imsic, ex); end
         5: begin
            if (lvl == 0) begin e.tag = "R5"; e.allow = !rw; end
            else if (lvl == 1) begin
               if (a == 12'h15C && !imsic) begin e.tag = "R12"; e.cause = 22; end
               else begin e.tag = "R14"; e.allow = hs_can(a, w, 0, 1, b58, b60, ssel, vsel, imsic, ex); end
            end else if (lvl == 2) begin
               if (hh) e.tag = "R11";
               else begin
                  e.tag = "R9";
                  if (hs_can(a, w, 0, 0, b58, b60, ssel, vsel, imsic, ex)) e.cause = 22;
               end
            end else e.tag = "R5";
         end
         4: begin
            if (lvl == 0) begin e.tag = "R5"; e.allow = !rw; end
            else if (lvl == 3) e.tag = "R5";
            else if (hh) e.tag = "R11";
            else begin
               e.tag = "R10";
               if (hs_can(a, w, 0, 0, b58, b60, ssel, vsel, imsic, ex)) e.cause = 22;
            end
         end
         default: ;
      endcase
      if (e.allow) e.cause = 0;
      return e;
   endfunction

   // compare the outputs against the oldest expectation (called at negedge)
   task automatic compare_now();
      expect_t e;
      if (pending.size() == 0) return;
      e = pending.pop_front();
      checks++;
      if (out_valid !== e.v) begin
         failures++;
         $display("FAIL R1 out_valid actual=%0b expected=%0b", out_valid, e.v);
      end
      if (e.v) begin
         checks++;
         if (out_allow !== e.allow || out_exc !== !e.allow || int'(out_cause) != e.cause) begin
            failures++;
            $display("FAIL %s priv/addr verdict actual allow=%0b exc=%0b cause=%0d expected allow=%0b cause=%0d",
                     e.tag, out_allow, out_exc, out_cause, e.allow, e.cause);
         end
         checks++;   // R2: cause consistent with allow flag
         if ((out_allow === 1'b1) != (out_cause == 0) ||
             !(out_cause == 0 || out_cause == 2 || out_cause == 22)) begin
            failures++;
            $display("FAIL R2 cause=%0d allow=%0b expected cause in {0,2,22} matching allow",
                     out_cause, out_allow);
         end
         last_allow = e.allow;
         last_cause = e.cause;
      end else begin
         checks++;   // R1: held verdict on idle cycles
         if (out_allow !== last_allow || int'(out_cause) != last_cause) begin
            failures++;
            $display("FAIL R1 held verdict actual allow=%0b cause=%0d expected allow=%0b cause=%0d",
                     out_allow, out_cause, last_allow, last_cause);
         end
      end
   endtask

   task automatic step(bit v, int prv, int a, bit w, bit tv, bit b58, bit b60,
                       int ssel, int vsel, bit aia, bit imsic);
      expect_t e;
      @(negedge clk);
      compare_now();
      req_valid = v;
      req_priv  = 3'(prv);
      req_addr  = 12'(a);
      req_write = w;
      tvm       = tv;
      stateen0  = '0;
      stateen0[58] = b58;
      stateen0[60] = b60;
      sisel_val = SEL_W'(ssel);
      vssel_val = SEL_W'(vsel);
      cfg_aia   = aia;
      cfg_imsic = imsic;
      if (v) e = reference(prv, a, w, tv, b58, b60, ssel, vsel, aia, imsic);
      else begin e.v = 0; e.allow = 0; e.cause = 0; e.tag = "R1"; end
      pending.push_back(e);
   endtask

   initial begin
      int n = 0;
      repeat (4) @(negedge clk);
      checks++;   // R1: reset state
      if (out_valid !== 1'b0 || out_allow !== 1'b0 || out_exc !== 1'b0 || out_cause !== 5'd0) begin
         failures++;
         $display("FAIL R1 reset state actual valid=%0b allow=%0b exc=%0b cause=%0d expected all zero",
                  out_valid, out_allow, out_exc, out_cause);
      end
      rst_n = 1'b1;
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int gate = 0; gate < 4; gate++) begin
            for (int sp = 0; sp < 3; sp++) begin
               int ss = (sp == 1) ? 5 : 0;
               int vs = (sp == 2) ? 7 : 0;
               for (int prv = 0; prv < 8; prv++) begin
                  for (int tv = 0; tv < 2; tv++) begin
                     for (int ai = 0; ai < 18; ai++) begin
                        for (int w = 0; w < 2; w++) begin
                           step(1'b1, prv, ADDRS[ai], w[0], tv[0], gate[0], gate[1],
                                ss, vs, cfg[1], cfg[0]);
                           n++;
                           if (n % 7 == 0) step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
                        end
                     end
                  end
               end
            end
         end
      end
      step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      compare_now();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 190000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule